// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It divides its input clock by a total ratio of 64·N + A and marks the end of each division period with a single-cycle pulse. That pulse is the compare signal a phase detector uses, and it can also be used to check the divider chain. The divider is a synchronous dual-modulus prescaler that counts 64 or 65 input clocks, a swallow counter that holds the A value, and a 12-bit main counter that holds N.

During one output period the prescaler runs N times. It divides by 65 for the first A runs and by 64 for the other N − A runs. N and A come in as plain control inputs from a control register. The counters sample them only at the terminal count, so a value written part way through a period has no effect on that period. A ratio that cannot be built (A larger than N, or N equal to zero) raises a sticky error flag. A standby input freezes the counters and holds the output low. There is no data stream, so every pin is a plain control or status pin with no handshake.

Top module: `pulse_swallow_div`

## Requirements
- R1: On reset, `div_pulse` and `ratio_err` are low. The first period after reset release is a fixed 64 input clocks, so the first pulse is high after the 64th rising edge. N and A are sampled at that first terminal count.
- R2: With 1 ≤ N and A ≤ N, consecutive rising edges of `div_pulse` are exactly 64·N + A input clocks apart. The prescaler divides by 65 for the first A prescaler runs of a period and by 64 for the rest.
- R3: At the boundaries, A = 0 gives a period of 64·N, and A = N gives 65·N. This includes N = 1 (64 and 65 clocks).
- R4: `n_val` and `a_val` are sampled only at the terminal count. A change made during a period leaves that period's length unchanged and sets the length of the following period.
- R5: `div_pulse` is active high and is high for exactly one input clock per period.
- R6: `ratio_err` goes high when the sampled values have A > N or N = 0. It stays high until reset, even after valid values are loaded. For such values the ratio is unspecified.
- R7: While `standby` is high, `div_pulse` is low and the counters hold their state. After standby is released the period continues, so it is longer by exactly the number of clocks spent in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | High freezes the counters and holds the output low |
| n_val | input | 12 | Main counter ratio N, sampled at terminal count |
| a_val | input | 6 | Swallow count A, sampled at terminal count |
| div_pulse | output | 1 | One-clock pulse once per division period |
| ratio_err | output | 1 | Sticky flag: values with A > N or N = 0 were sampled |

## Verification
The assertions take for granted that `standby` is a clean synchronous level and that N and A only matter at the terminal count. The assertion on a bounded prescaler count also relies on the swallow state changing only at a prescaler terminal. The stimulus drives every input on the falling edge, so nothing changes at a sampling edge. Valid ratios keep A ≤ N with N ≥ 1, and the two illegal settings are each followed by a reset. This keeps the long wrap-around period that N = 0 would produce out of the run.

// File: rtl/psd_pkg.sv
package psd_pkg;
  parameter int unsigned PSD_N_W     = 12;
  parameter int unsigned PSD_A_W     = 6;
  parameter int unsigned PSD_PRE_LOG = 6;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned PRE_LOG = psd_pkg::PSD_PRE_LOG
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic swallow,
  output logic term
);
  localparam int unsigned CW = PRE_LOG + 1;
  localparam logic [CW-1:0] LAST_BASE = CW'((1 << PRE_LOG) - 1);
  localparam logic [CW-1:0] LAST_SWAL = CW'(1 << PRE_LOG);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = swallow ? LAST_SWAL : LAST_BASE;
  assign term = en && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (term)    cnt <= '0;
    else if (en)      cnt <= cnt + 1'b1;
  end

  // R2: the count never passes the extended modulus
  p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_SWAL);

  // R7: count frozen while disabled
  p_pre_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/psd_cycle_ctr.sv
module psd_cycle_ctr #(
  parameter int unsigned N_W = psd_pkg::PSD_N_W,
  parameter int unsigned A_W = psd_pkg::PSD_A_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           pre_term,
  input  logic [N_W-1:0] n_in,
  input  logic [A_W-1:0] a_in,
  output logic           swallow,
  output logic           period_end
);
  logic [N_W-1:0] n_left;
  logic [A_W-1:0] a_left;

  assign swallow    = (a_left != '0);
  assign period_end = pre_term && (n_left == N_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_left <= N_W'(1);
      a_left <= '0;
    end else if (pre_term) begin
      if (n_left == N_W'(1)) begin
        n_left <= n_in;
        a_left <= a_in;
      end else begin
        n_left <= n_left - 1'b1;
        if (a_left != '0) a_left <= a_left - 1'b1;
      end
    end
  end

  // R4: the counters move only on a prescaler terminal, so new values wait for terminal count
  p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_term |=> ($stable(n_left) && $stable(a_left)));

  // R7: no prescaler terminal while held
  p_no_term_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pre_term);
endmodule

// File: rtl/psd_ratio_guard.sv
module psd_ratio_guard #(
  parameter int unsigned N_W = psd_pkg::PSD_N_W,
  parameter int unsigned A_W = psd_pkg::PSD_A_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N_W-1:0] n_in,
  input  logic [A_W-1:0] a_in,
  output logic           err
);
  localparam int unsigned CMP_W = (N_W > A_W) ? N_W : A_W;

  logic bad;
  assign bad = (CMP_W'(n_in) < CMP_W'(a_in)) || (n_in == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            err <= 1'b0;
    else if (load && bad)  err <= 1'b1;
  end

  // R6: once raised the flag stays up until reset
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R6: the flag only rises on a terminal-count load
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(load));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int unsigned N_W     = psd_pkg::PSD_N_W,
  parameter int unsigned A_W     = psd_pkg::PSD_A_W,
  parameter int unsigned PRE_LOG = psd_pkg::PSD_PRE_LOG
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           standby,
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  output logic           div_pulse,
  output logic           ratio_err
);
  logic en;
  logic swallow;
  logic pre_term;
  logic period_end;
  logic pulse_r;

  assign en = !standby;

  psd_prescaler #(.PRE_LOG(PRE_LOG)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .swallow (swallow),
    .term    (pre_term)
  );

  psd_cycle_ctr #(.N_W(N_W), .A_W(A_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .pre_term   (pre_term),
    .n_in       (n_val),
    .a_in       (a_val),
    .swallow    (swallow),
    .period_end (period_end)
  );

  psd_ratio_guard #(.N_W(N_W), .A_W(A_W)) u_guard (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (period_end),
    .n_in  (n_val),
    .a_in  (a_val),
    .err   (ratio_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_r <= 1'b0;
    else        pulse_r <= period_end;
  end

  assign div_pulse = pulse_r && !standby;

  // R5: pulse is a single clock wide
  p_one_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R7: the pulse register stays clear through standby
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !pulse_r);
endmodule

// File: tb/pulse_swallow_div_test.sv
module pulse_swallow_div_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sb = 1'b0;
  logic [11:0] nv = 12'd3;
  logic [5:0]  av = 6'd1;
  logic        div_pulse;
  logic        ratio_err;
  int checks = 0;
  int failures = 0;
  localparam int LIMIT = 30000;

  always #10 clk = ~clk;

  pulse_swallow_div uut (
    .clk(clk), .rst_n(rst_n), .standby(sb),
    .n_val(nv), .a_val(av),
    .div_pulse(div_pulse), .ratio_err(ratio_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // counts negedges until the pulse is seen; also checks width (R5)
  task automatic measure(output int p);
    p = 0;
    do begin
      @(negedge clk);
      p++;
      if (p == 1) chk(!div_pulse, "R5 width", int'(div_pulse), 0);
    end while (!div_pulse && p < LIMIT);
  endtask

  task automatic t_reset(input logic [11:0] n0, input logic [5:0] a0);
    int p;
    rst_n = 1'b0; sb = 1'b0; nv = n0; av = a0;
    repeat (3) @(negedge clk);
    chk(!div_pulse && !ratio_err, "R1 reset outputs", int'({div_pulse, ratio_err}), 0);
    rst_n = 1'b1;
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!div_pulse && p < LIMIT);
    chk(p == 64, "R1 first period", p, 64);
  endtask

  task automatic t_ratio(input int n, input int a, input string req);
    int p;
    nv = 12'(n); av = 6'(a);
    measure(p);
    measure(p);
    chk(p == 64 * n + a, req, p, 64 * n + a);
  endtask

  task automatic t_defer();
    int p;
    nv = 12'd3; av = 6'd1;
    measure(p);
    p = 0;
    do begin
      @(negedge clk);
      p++;
      if (p == 10) begin nv = 12'd4; av = 6'd2; end
    end while (!div_pulse && p < LIMIT);
    chk(p == 193, "R4 old period kept", p, 193);
    measure(p);
    chk(p == 258, "R4 new period", p, 258);
  endtask

  task automatic t_standby(input int start, input int len);
    int p;
    bit low_ok;
    nv = 12'd3; av = 6'd1;
    measure(p);
    p = 0; low_ok = 1'b1;
    do begin
      @(negedge clk);
      p++;
      if (sb && div_pulse) low_ok = 1'b0;
      if (p == start) sb = 1'b1;
      if (p == start + len) sb = 1'b0;
    end while (!div_pulse && p < LIMIT);
    chk(low_ok, "R7 low in standby", int'(low_ok), 1);
    chk(p == 193 + len, "R7 stretched period", p, 193 + len);
  endtask

  task automatic t_error_swap();
    int p;
    nv = 12'd2; av = 6'd5;
    measure(p);
    chk(ratio_err, "R6 set on A>N", int'(ratio_err), 1);
    nv = 12'd3; av = 6'd1;
    measure(p);
    measure(p);
    chk(ratio_err, "R6 sticky", int'(ratio_err), 1);
    chk(p == 193, "R6 valid ratio after error", p, 193);
  endtask

  task automatic t_error_zero();
    t_reset(12'd0, 6'd0);
    chk(ratio_err, "R6 set on N=0", int'(ratio_err), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    t_reset(12'd3, 6'd1);
    t_ratio(3, 1, "R2 N3 A1");
    t_ratio(40, 17, "R2 N40 A17");
    t_ratio(200, 63, "R2 N200 A63");
    t_ratio(5, 0, "R3 A=0");
    t_ratio(5, 5, "R3 A=N");
    t_ratio(1, 0, "R3 N1 A0");
    t_ratio(1, 1, "R3 N1 A1");
    t_defer();
    t_standby(20, 37);
    t_standby(100, 300);
    t_error_swap();
    t_reset(12'd3, 6'd1);
    chk(!ratio_err, "R6 cleared by reset", int'(ratio_err), 0);
    t_error_zero();
    t_reset(12'd3, 6'd1);
    t_ratio(7, 3, "R2 after recovery");
    summary();
  end
endmodule